// File: doc/BRIEF.md
# Smart card activation sequencer

This block is the digital controller of a contact smart card reader front end. It powers the card up and down in a fixed series of timed steps. The host asks for a card session by pulling an active-low request line and gives the card reset level on a separate input. The block drives the card-supply enable, the supply ramp start, the supply voltage code, the I/O enable, the card clock enable and the card reset. All step times are counted in half-quanta of a time quantum T. T is 64 periods of the internal timebase, so one half-quantum is `HQ_CYCLES` clock cycles.

An active-low status line tells the host about the card. Outside a session it shows the debounced card presence. During a session any fault, or the removal of the card, pulls it low and starts an emergency power-down. Overcurrent, overtemperature and supply-low are modelled as digital inputs. A supply-good input shows when the card supply has fully collapsed. A low-power stop state is entered from the idle state through a three-pin code. Leaving it applies a power-up delay followed by a fresh presence debounce. The insertion debounce and the power-up delay are parameters in clock cycles, so a test can shorten them.

Top module: `sc_sequencer`

## Requirements
- R1: `vcc_sel` encodes the supply choice: 2'b10 = 1.8 V when `sel_1v8` is high (whatever `sel_5v` is), otherwise 2'b01 = 5 V when `sel_5v` is high and 2'b00 = 3 V when it is low. The code follows the select pins one cycle later while idle, and it is frozen from the start of activation until the block is idle again.
- R2: A session starts on the first clock edge that sees `cmd_n` low after it was high. At that edge `vcc_en` rises. `vcc_ramp` rises 3·HQ_CYCLES cycles later, `io_en` rises 8·HQ_CYCLES cycles later, and activation ends 14·HQ_CYCLES cycles later. `io_en` is never high without `vcc_en`.
- R3: `card_rst` stays low during activation, whatever `host_rst` is. From the end of activation it copies `host_rst` with a latency of one cycle.
- R4: If `host_rst` was low at the start edge, `clk_en` rises together with `io_en`. If it was high, `clk_en` rises one cycle after `host_rst` is seen low while `io_en` is high, or at the end of activation at the latest. After the end of activation, `host_rst` has no effect on `clk_en`. `clk_en` is never high without `io_en`.
- R5: A normal power-down starts at the first edge that sees `cmd_n` high during a session. At that edge `card_rst` falls. `clk_en` falls HQ_CYCLES cycles later, `io_en` falls 2·HQ_CYCLES cycles later, and `vcc_en` and `vcc_ramp` fall 6·HQ_CYCLES cycles later.
- R6: During a session, a high fault input or the loss of card presence makes `irq_n` low one cycle later, and the R5 power-down starts at that same edge. `irq_n` stays low until the block is idle again.
- R7: Outside a session, `irq_n` is high exactly when the card is present and debounced. The fault inputs have no effect on it.
- R8: Presence becomes valid after `card_in` has been seen high on DEB_CYC consecutive edges; a low sample restarts the count. A card removal clears presence, and so `irq_n`, at once, with no clock edge between.
- R9: Stop mode is entered only from idle, when `cmd_n`, `sel_5v` and `sel_1v8` are all high; a power-down in progress runs to its end first. In stop mode `irq_n` copies `card_in` directly.
- R10: When any of the three stop pins goes low, `irq_n` is held low for PWRUP_CYC cycles. After that a fresh DEB_CYC-edge debounce runs, so `irq_n` can rise no earlier than PWRUP_CYC+DEB_CYC+1 edges after the exit edge.
- R11: Activation needs valid presence at the falling edge of `cmd_n`. A request that was already low when the block became idle does not start a session.
- R12: After the supply is switched off, the block stays in power-down (and ignores new requests) until `vcc_good` is low. It then becomes idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_n | input | 1 | Host session request, active low |
| host_rst | input | 1 | Reset level requested by the host |
| sel_5v | input | 1 | 5 V (high) / 3 V (low) select |
| sel_1v8 | input | 1 | 1.8 V select, overrides sel_5v |
| card_in | input | 1 | Raw card presence, active high |
| flt_ovc | input | 1 | Supply overcurrent flag |
| flt_otp | input | 1 | Overtemperature flag |
| flt_uv | input | 1 | Host supply low flag |
| vcc_good | input | 1 | Card supply still above its off level |
| vcc_en | output | 1 | Card supply enable |
| vcc_ramp | output | 1 | Start of the controlled supply ramp |
| vcc_sel | output | 2 | Supply voltage code (R1) |
| io_en | output | 1 | Data line enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset output |
| irq_n | output | 1 | Status / interrupt, active low |
| stop_o | output | 1 | High while in stop mode |

## Verification
Every result is counted in falling clock edges from the edge at which its stimulus was driven. The start of activation shows on `vcc_en` one edge after `cmd_n` falls. The later steps come n·HQ_CYCLES edges after that, and the power-down steps follow the same rule from the `cmd_n` rise or the fault. The bench samples each step on the edge before its due time, expecting the old value, and again on the due edge, expecting the new one. The debounce and wake checks are placed one edge on either side of the DEB_CYC and PWRUP_CYC+DEB_CYC+1 boundaries. Presence removal and the stop-mode status are checked a fraction of a cycle after the input changes, because they go through no register.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACT   = 3'd1,
    ST_ON    = 3'd2,
    ST_DEACT = 3'd3,
    ST_STOP  = 3'd4,
    ST_WAKE  = 3'd5
  } seq_st_e;

  typedef enum logic [1:0] {
    VS_3V0 = 2'b00,
    VS_5V0 = 2'b01,
    VS_1V8 = 2'b10
  } vsel_e;

  // step positions in half-quanta of T
  localparam int unsigned HALF_RAMP   = 3;
  localparam int unsigned HALF_IO     = 8;
  localparam int unsigned HALF_ON     = 14;
  localparam int unsigned HALF_CLKOFF = 1;
  localparam int unsigned HALF_IOOFF  = 2;
  localparam int unsigned HALF_VOFF   = 6;

  // counter value seen on the edge that makes a step visible
  function automatic int unsigned step_mark(int unsigned halves, int unsigned hq);
    return halves * hq - 1;
  endfunction

  function automatic vsel_e pick_vsel(logic s18, logic s5);
    if (s18)     return VS_1V8;
    else if (s5) return VS_5V0;
    else         return VS_3V0;
  endfunction

endpackage

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/sc_pres_debounce.sv
module sc_pres_debounce #(
  parameter int unsigned DEB_CYC = 20480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_in,
  input  logic hold,
  output logic pres_ok
);
  localparam int unsigned DW = $clog2(DEB_CYC + 1);
  localparam logic [DW-1:0] DEB_END = DW'(DEB_CYC);

  logic [DW-1:0] deb_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 deb_cnt <= '0;
    else if (!card_in || hold)  deb_cnt <= '0;
    else if (deb_cnt != DEB_END) deb_cnt <= deb_cnt + 1'b1;
  end

  // removal acts without a clock edge
  assign pres_ok = card_in && (deb_cnt == DEB_END);

  AST_DEB_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres_ok) |-> ($past(card_in) && !$past(hold))); // R8

endmodule

// File: rtl/sc_vsel_decode.sv
module sc_vsel_decode
  import sc_seq_pkg::*;
(
  input  logic  s18,
  input  logic  s5,
  output vsel_e code
);
  assign code = pick_vsel(s18, s5);
endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import sc_seq_pkg::*;
#(
  parameter int unsigned HQ_CYCLES = 32,
  parameter int unsigned DEB_CYC   = 20480,
  parameter int unsigned PWRUP_CYC = 563
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_n,
  input  logic       host_rst,
  input  logic       sel_5v,
  input  logic       sel_1v8,
  input  logic       card_in,
  input  logic       flt_ovc,
  input  logic       flt_otp,
  input  logic       flt_uv,
  input  logic       vcc_good,
  output logic       vcc_en,
  output logic       vcc_ramp,
  output logic [1:0] vcc_sel,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       irq_n,
  output logic       stop_o
);
  localparam int unsigned SEQ_SPAN = HALF_ON * HQ_CYCLES;
  localparam int unsigned SPAN     = (SEQ_SPAN > PWRUP_CYC) ? SEQ_SPAN : PWRUP_CYC;
  localparam int unsigned CW       = $clog2(SPAN + 1);

  localparam logic [CW-1:0] M_RAMP   = CW'(step_mark(HALF_RAMP,   HQ_CYCLES));
  localparam logic [CW-1:0] M_IO     = CW'(step_mark(HALF_IO,     HQ_CYCLES));
  localparam logic [CW-1:0] M_ON     = CW'(step_mark(HALF_ON,     HQ_CYCLES));
  localparam logic [CW-1:0] M_CLKOFF = CW'(step_mark(HALF_CLKOFF, HQ_CYCLES));
  localparam logic [CW-1:0] M_IOOFF  = CW'(step_mark(HALF_IOOFF,  HQ_CYCLES));
  localparam logic [CW-1:0] M_VOFF   = CW'(step_mark(HALF_VOFF,   HQ_CYCLES));
  localparam logic [CW-1:0] M_WAKE   = CW'(PWRUP_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt;
  logic          cmd_prev, fault_q, rst_at_start, pres_ok;
  vsel_e         vsel_live, vsel_q;

  // named events
  logic in_session, fault_any, abort, start_req, stop_code, act_done, deact_done, wake_done;

  assign in_session = (st_q == ST_ACT) || (st_q == ST_ON);
  assign fault_any  = flt_ovc || flt_otp || flt_uv;
  assign abort      = in_session && (fault_any || !pres_ok);
  assign stop_code  = cmd_n && sel_5v && sel_1v8;
  assign start_req  = (st_q == ST_IDLE) && cmd_prev && !cmd_n && pres_ok;
  assign act_done   = (st_q == ST_ACT) && (cnt == M_ON);
  assign deact_done = (st_q == ST_DEACT) && !vcc_en && !vcc_good;
  assign wake_done  = (st_q == ST_WAKE) && (cnt == M_WAKE);

  sc_step_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .cnt(cnt)
  );

  sc_pres_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .card_in(card_in),
    .hold((st_q == ST_STOP) || (st_q == ST_WAKE)), .pres_ok(pres_ok)
  );

  sc_vsel_decode u_vsel (.s18(sel_1v8), .s5(sel_5v), .code(vsel_live));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_req) st_d = ST_ACT;
                else if (stop_code) st_d = ST_STOP;
      ST_ACT:   if (abort || cmd_n) st_d = ST_DEACT;
                else if (act_done) st_d = ST_ON;
      ST_ON:    if (abort || cmd_n) st_d = ST_DEACT;
      ST_DEACT: if (deact_done) st_d = ST_IDLE;
      ST_STOP:  if (!stop_code) st_d = ST_WAKE;
      ST_WAKE:  if (wake_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cmd_prev <= 1'b1;
      fault_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      cmd_prev <= cmd_n;
      if (st_d == ST_IDLE) fault_q <= 1'b0;
      else if (abort)      fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_en <= 1'b0; vcc_ramp <= 1'b0; io_en <= 1'b0; clk_en <= 1'b0;
      card_rst <= 1'b0; rst_at_start <= 1'b0; vsel_q <= VS_3V0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          vsel_q <= vsel_live;
          if (start_req) begin
            vcc_en       <= 1'b1;
            rst_at_start <= host_rst;
          end
        end
        ST_ACT: if (st_d == ST_ACT || st_d == ST_ON) begin
          if (cnt == M_RAMP) vcc_ramp <= 1'b1;
          if (cnt == M_IO) begin
            io_en <= 1'b1;
            if (!rst_at_start) clk_en <= 1'b1;
          end
          if (io_en && rst_at_start && !host_rst) clk_en <= 1'b1;
          if (act_done) begin
            clk_en   <= 1'b1;
            card_rst <= host_rst;
          end
        end
        ST_ON: card_rst <= (st_d == ST_ON) ? host_rst : 1'b0;
        ST_DEACT: begin
          card_rst <= 1'b0;
          if (cnt == M_CLKOFF) clk_en <= 1'b0;
          if (cnt == M_IOOFF)  io_en  <= 1'b0;
          if (cnt == M_VOFF) begin
            vcc_en   <= 1'b0;
            vcc_ramp <= 1'b0;
          end
        end
        default: begin
          vcc_en <= 1'b0; vcc_ramp <= 1'b0; io_en <= 1'b0;
          clk_en <= 1'b0; card_rst <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_STOP: irq_n = card_in;
      ST_WAKE: irq_n = 1'b0;
      default: irq_n = pres_ok && !fault_q;
    endcase
  end

  assign stop_o  = (st_q == ST_STOP);
  assign vcc_sel = vsel_q;

  AST_IO_UNDER_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en); // R2
  AST_NO_RST_IN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT) |-> !card_rst); // R3
  AST_CLK_UNDER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en); // R4
  AST_DEACT_RST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEACT) |-> !card_rst); // R5
  AST_ABORT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !irq_n); // R6
  AST_STOP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_o) |-> ($past(st_q == ST_IDLE) && !vcc_en)); // R9
  AST_VSEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_session) && in_session) |-> $stable(vcc_sel)); // R1

endmodule

// File: tb/sc_sequencer_bench.sv
module sc_sequencer_bench;
  localparam int unsigned HQ  = 2;
  localparam int unsigned DEB = 20;
  localparam int unsigned PWU = 10;

  logic clk = 1'b0;
  logic rst_n, cmd_n, host_rst, sel_5v, sel_1v8, card_in;
  logic flt_ovc, flt_otp, flt_uv, vcc_good;
  logic vcc_en, vcc_ramp, io_en, clk_en, card_rst, irq_n, stop_o;
  logic [1:0] vcc_sel;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sc_sequencer #(.HQ_CYCLES(HQ), .DEB_CYC(DEB), .PWRUP_CYC(PWU)) u_sc_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .host_rst(host_rst),
    .sel_5v(sel_5v), .sel_1v8(sel_1v8), .card_in(card_in),
    .flt_ovc(flt_ovc), .flt_otp(flt_otp), .flt_uv(flt_uv), .vcc_good(vcc_good),
    .vcc_en(vcc_en), .vcc_ramp(vcc_ramp), .vcc_sel(vcc_sel), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .irq_n(irq_n), .stop_o(stop_o)
  );

  // {sel_1v8, sel_5v, expected code}
  localparam logic [3:0] VSEL_TAB [4] = '{4'b0000, 4'b0101, 4'b1010, 4'b1110};

  task automatic chk(input string req, input string what, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_n = 1; host_rst = 0; sel_5v = 0; sel_1v8 = 0; card_in = 0;
    flt_ovc = 0; flt_otp = 0; flt_uv = 0; vcc_good = 0;
    tick(3);
    chk("R2", "vcc_en in reset", vcc_en, 0);
    chk("R4", "clk_en in reset", clk_en, 0);
    chk("R3", "card_rst in reset", card_rst, 0);
    chk("R7", "irq_n in reset, no card", irq_n, 0);
    rst_n = 1;
    tick(1);

    // R1 select table, no card so no session starts
    cmd_n = 0;
    for (int i = 0; i < 4; i++) begin
      sel_1v8 = VSEL_TAB[i][3];
      sel_5v  = VSEL_TAB[i][2];
      tick(1);
      chk("R1", "vcc_sel idle", vcc_sel, VSEL_TAB[i][1:0]);
    end
    chk("R11", "no start without card", vcc_en, 0);
    sel_1v8 = 0; sel_5v = 0; cmd_n = 1;
    tick(2);

    // R8 debounce with one bounce
    card_in = 1; tick(10);
    card_in = 0; tick(1);
    card_in = 1; tick(DEB - 1);
    chk("R8", "irq_n before debounce end", irq_n, 0);
    tick(1);
    chk("R8", "irq_n at debounce end", irq_n, 1);
    flt_otp = 1; tick(2);
    chk("R7", "fault ignored idle irq_n", irq_n, 1);
    chk("R7", "fault ignored idle vcc_en", vcc_en, 0);
    flt_otp = 0;

    // activation A: host_rst high, 5 V
    sel_5v = 1; tick(1);
    host_rst = 1; cmd_n = 0;
    tick(1);
    chk("R2", "vcc_en at start", vcc_en, 1);
    chk("R1", "vcc_sel 5V", vcc_sel, 2'b01);
    tick(5);  chk("R2", "ramp before 1.5T", vcc_ramp, 0);
    tick(1);  chk("R2", "ramp at 1.5T", vcc_ramp, 1);
    tick(9);  chk("R2", "io before 4T", io_en, 0);
    tick(1);  chk("R2", "io at 4T", io_en, 1);
    chk("R4", "clk waits, host_rst high", clk_en, 0);
    sel_1v8 = 1;
    tick(10); chk("R3", "card_rst low in activation", card_rst, 0);
    tick(1);  chk("R4", "clk before 7T", clk_en, 0);
    tick(1);  chk("R4", "clk at 7T", clk_en, 1);
    chk("R3", "card_rst copies host_rst", card_rst, 1);
    chk("R1", "vcc_sel frozen", vcc_sel, 2'b01);
    vcc_good = 1; host_rst = 0;
    tick(1);
    chk("R3", "card_rst follows low", card_rst, 0);
    chk("R4", "clk unaffected after end", clk_en, 1);
    sel_1v8 = 0;

    // deactivation B
    cmd_n = 1;
    tick(1);  chk("R5", "card_rst low at t10", card_rst, 0);
    chk("R5", "clk still on", clk_en, 1);
    tick(2);  chk("R5", "clk off at 0.5T", clk_en, 0);
    chk("R5", "io still on", io_en, 1);
    tick(2);  chk("R5", "io off at T", io_en, 0);
    tick(7);  chk("R5", "vcc before 3T", vcc_en, 1);
    tick(1);  chk("R5", "vcc off at 3T", vcc_en, 0);
    chk("R5", "ramp off at 3T", vcc_ramp, 0);
    cmd_n = 0; tick(3);
    chk("R12", "waits for vcc_good", vcc_en, 0);
    cmd_n = 1; vcc_good = 0; tick(2);

    // activation C: host_rst low, then fault
    cmd_n = 0;
    tick(16); chk("R4", "clk before io time", clk_en, 0);
    tick(1);  chk("R4", "clk with io", clk_en, 1);
    tick(12); vcc_good = 1;
    flt_ovc = 1;
    tick(1);  chk("R6", "irq_n low after fault", irq_n, 0);
    flt_ovc = 0;
    tick(2);  chk("R6", "emergency clk off", clk_en, 0);
    tick(10); chk("R6", "emergency vcc off", vcc_en, 0);
    chk("R6", "irq_n held low", irq_n, 0);
    vcc_good = 0;
    tick(1);  chk("R6", "irq_n back high when idle", irq_n, 1);
    tick(3);  chk("R11", "held-low request ignored", vcc_en, 0);
    cmd_n = 1; tick(1);

    // activation D: early clock, then removal
    host_rst = 1; cmd_n = 0;
    tick(19); chk("R4", "clk waits for host_rst", clk_en, 0);
    host_rst = 0;
    tick(1);  chk("R4", "clk on host_rst low", clk_en, 1);
    chk("R3", "card_rst low before end", card_rst, 0);
    card_in = 0; #1;
    chk("R8", "removal clears irq_n at once", irq_n, 0);
    tick(3);  chk("R6", "removal clk off", clk_en, 0);
    tick(12); chk("R6", "removal vcc off", vcc_en, 0);
    cmd_n = 1;

    // stop mode
    card_in = 1; tick(DEB + 1);
    chk("R8", "present again", irq_n, 1);
    cmd_n = 0; tick(29);
    sel_1v8 = 1; sel_5v = 1; cmd_n = 1;
    tick(5);  chk("R9", "no stop during power-down", stop_o, 0);
    chk("R9", "power-down still running", vcc_en, 1);
    tick(10); chk("R9", "stop after power-down", stop_o, 1);
    card_in = 0; #1;
    chk("R9", "stop irq_n follows card low", irq_n, 0);
    card_in = 1; #1;
    chk("R9", "stop irq_n follows card high", irq_n, 1);
    tick(1);
    sel_5v = 0;
    tick(1);  chk("R10", "stop exit", stop_o, 0);
    chk("R10", "irq_n low on wake", irq_n, 0);
    tick(PWU + DEB - 1); chk("R10", "irq_n before wake+debounce", irq_n, 0);
    tick(1);  chk("R10", "irq_n after wake+debounce", irq_n, 1);
    chk("R1", "vcc_sel 1.8V priority", vcc_sel, 2'b10);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule